// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards a shared medium against a transmitter that never lets go. It watches a transmit-active input every clock cycle and counts how long a single transmission has lasted. When that run exceeds a configured limit, the block removes the transmit enable, requests a collision indication and latches a jabber status flag.

Recovery happens in a second phase. Once the transmit input has gone quiet, a longer unjab timer starts. Only after the input has stayed idle for the full unjab interval does the block restore the transmit enable and withdraw the collision request. If the input becomes active again before that, the unjab count starts over.

The status flag stays set after recovery until software writes a one-cycle clear pulse or reset is applied. Power-down and port deselect force the block back to normal operation at once. Both intervals are parameters given in clock cycles, so a bench can shrink them. The defaults are 50 ms and 500 ms at 125 MHz.

Top module: `jab_watchdog`

## Requirements
- R1: After reset is released, tx_en is 1, col_req is 0 and jab_status is 0.
- R2: If tx_active is sampled high on JAB_CYCLES consecutive rising edges while operating normally, then after the last of those edges tx_en is 0.
- R3: A low sample of tx_active before the limit is reached restarts the jabber count from zero, so runs of JAB_CYCLES-1 high samples separated by single low samples never cut the transmitter.
- R4: On the same edge where tx_en is removed, col_req becomes 1 and jab_status becomes 1.
- R5: While cut off, tx_en stays 0 and col_req stays 1 for as long as tx_active remains high.
- R6: While cut off, after UNJAB_CYCLES consecutive low samples of tx_active, tx_en returns to 1 and col_req returns to 0 after the last of those edges.
- R7: A high sample of tx_active during the unjab phase restarts the unjab count from zero.
- R8: jab_status remains 1 after recovery and is cleared only by reset or by a one-cycle high pulse on jab_clr. When a new jabber event and the clear pulse occur on the same edge, the new event wins.
- R9: While pwr_down is 1 or port_sel is 0, the block returns to normal operation on the next edge, with tx_en 1, col_req 0 and both counts cleared. jab_status is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_active | input | 1 | Transmit data stream present |
| pwr_down | input | 1 | Power-down request, forces normal operation |
| port_sel | input | 1 | Twisted-pair port selected; 0 forces normal operation |
| jab_clr | input | 1 | One-cycle pulse that clears jab_status |
| tx_en | output | 1 | Transmit enable gate |
| col_req | output | 1 | Collision request, ORed into collision status |
| jab_status | output | 1 | Sticky jabber flag |

## Verification
The bench builds the block with JAB_CYCLES set to 20 and UNJAB_CYCLES set to 50, instead of millions of cycles. At that scale it can walk every boundary in a few hundred cycles. It sends runs one cycle short of each limit and runs that reach each limit exactly. It also interrupts the unjab phase one cycle before it would expire. Power-down and deselect are each applied in the middle of a cut-off, and the clear pulse is checked both alone and on the same edge as a new jabber event.

// File: rtl/jab_pkg.sv
package jab_pkg;
  typedef enum logic [0:0] {
    ST_RUN  = 1'b0,
    ST_LOCK = 1'b1
  } jab_state_e;
endpackage

// File: rtl/jab_rst_sync.sv
module jab_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/jab_interval_timer.sv
module jab_interval_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cnt_en,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done = cnt_en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (cnt_en) cnt_d = done ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3 R7: the count never passes its limit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R3 R7: a clear request empties the count on the next edge
  a_r7_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/jab_ctrl.sv
module jab_ctrl
  import jab_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic quiesce,
  input  logic jab_clr,
  input  logic jab_done,
  input  logic unjab_done,
  output logic jab_clr_cnt,
  output logic jab_cnt_en,
  output logic unjab_clr_cnt,
  output logic unjab_cnt_en,
  output logic tx_en,
  output logic col_req,
  output logic jab_status
);
  jab_state_e st_q, st_d;
  logic       sticky_q, sticky_d;
  logic       enter_lock;

  assign jab_cnt_en    = (st_q == ST_RUN) && tx_active && !quiesce;
  assign jab_clr_cnt   = quiesce || !tx_active || (st_q != ST_RUN);
  assign unjab_cnt_en  = (st_q == ST_LOCK) && !tx_active && !quiesce;
  assign unjab_clr_cnt = quiesce || tx_active || (st_q != ST_LOCK);

  assign enter_lock = (st_q == ST_RUN) && jab_done && !quiesce;

  always_comb begin
    st_d = st_q;
    if (quiesce) st_d = ST_RUN;
    else begin
      unique case (st_q)
        ST_RUN:  if (jab_done)   st_d = ST_LOCK;
        ST_LOCK: if (unjab_done) st_d = ST_RUN;
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_comb begin
    sticky_d = sticky_q;
    if (jab_clr)    sticky_d = 1'b0;
    if (enter_lock) sticky_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RUN;
      sticky_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      sticky_q <= sticky_d;
    end
  end

  assign tx_en      = (st_q == ST_RUN);
  assign col_req    = (st_q == ST_LOCK);
  assign jab_status = sticky_q;

  // R4: the status flag is set whenever the gate closes
  a_r4_flag_on_cut: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> jab_status);
  // R5: an active stream keeps the transmitter cut
  a_r5_stay_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && tx_active && !quiesce) |=> !tx_en);
  // R3: an idle sample while enabled never cuts
  a_r3_idle_safe: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !tx_active) |=> tx_en);
  // R8: the flag holds without a clear
  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (jab_status && !jab_clr) |=> jab_status);
  // R9: power-down or deselect restores normal operation
  a_r9_quiesce_run: assert property (@(posedge clk) disable iff (!rst_n)
    quiesce |=> (tx_en && !col_req));
  // R6: reopening only follows a quiet input
  a_r6_reopen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_en) && !$past(quiesce)) |-> !$past(tx_active));
endmodule

// File: rtl/jab_watchdog.sv
module jab_watchdog #(
  parameter int JAB_CYCLES   = 6_250_000,
  parameter int UNJAB_CYCLES = 62_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic pwr_down,
  input  logic port_sel,
  input  logic jab_clr,
  output logic tx_en,
  output logic col_req,
  output logic jab_status
);
  logic srst_n;
  logic quiesce;
  logic jab_done, unjab_done;
  logic jab_clr_cnt, jab_cnt_en, unjab_clr_cnt, unjab_cnt_en;

  assign quiesce = pwr_down || !port_sel;

  jab_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  jab_interval_timer #(.LIMIT(JAB_CYCLES)) u_jab_tmr (
    .clk    (clk),
    .rst_n  (srst_n),
    .clr    (jab_clr_cnt),
    .cnt_en (jab_cnt_en),
    .done   (jab_done)
  );

  jab_interval_timer #(.LIMIT(UNJAB_CYCLES)) u_unjab_tmr (
    .clk    (clk),
    .rst_n  (srst_n),
    .clr    (unjab_clr_cnt),
    .cnt_en (unjab_cnt_en),
    .done   (unjab_done)
  );

  jab_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (srst_n),
    .tx_active     (tx_active),
    .quiesce       (quiesce),
    .jab_clr       (jab_clr),
    .jab_done      (jab_done),
    .unjab_done    (unjab_done),
    .jab_clr_cnt   (jab_clr_cnt),
    .jab_cnt_en    (jab_cnt_en),
    .unjab_clr_cnt (unjab_clr_cnt),
    .unjab_cnt_en  (unjab_cnt_en),
    .tx_en         (tx_en),
    .col_req       (col_req),
    .jab_status    (jab_status)
  );
endmodule

// File: tb/jab_watchdog_bench.sv
`timescale 1ns/1ps
module jab_watchdog_bench;
  localparam int J = 20;
  localparam int U = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_active = 1'b0, pwr_down = 1'b0, port_sel = 1'b1, jab_clr = 1'b0;
  logic tx_en, col_req, jab_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic en;
    logic col;
    logic st;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  jab_watchdog #(.JAB_CYCLES(J), .UNJAB_CYCLES(U)) u_jab_watchdog (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .pwr_down(pwr_down),
    .port_sel(port_sel), .jab_clr(jab_clr), .tx_en(tx_en),
    .col_req(col_req), .jab_status(jab_status)
  );

  // monitor: compare the queued expectation away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (tx_en !== e.en || col_req !== e.col || jab_status !== e.st) begin
        errors++;
        $display("FAIL %s: got en=%b col=%b st=%b expected en=%b col=%b st=%b",
                 e.tag, tx_en, col_req, jab_status, e.en, e.col, e.st);
      end
    end
  end

  // driver: one cycle of stimulus, then push the expected outputs
  task automatic cyc(input logic tx, input logic pd, input logic sel,
                     input logic clr, input logic en, input logic col,
                     input logic st, input string tag);
    @(negedge clk);
    tx_active = tx; pwr_down = pd; port_sel = sel; jab_clr = clr;
    @(posedge clk);
    #1;
    q.push_back('{en: en, col: col, st: st, tag: tag});
  endtask

  task automatic run(input int n, input logic tx, input logic en,
                     input logic col, input logic st, input string tag);
    for (int i = 0; i < n; i++) cyc(tx, 1'b0, 1'b1, 1'b0, en, col, st, tag);
  endtask

  // drive one jabber event: J high samples, cut on the last
  task automatic jab_event(input string tag);
    run(J - 1, 1'b1, 1'b1, 1'b0, jab_status, tag);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    run(2, 1'b0, 1'b1, 1'b0, 1'b0, "R1 reset state");

    // R3: runs one short of the limit with single idle gaps
    for (int k = 0; k < 3; k++) begin
      run(J - 1, 1'b1, 1'b1, 1'b0, 1'b0, "R3 short run");
      run(1, 1'b0, 1'b1, 1'b0, 1'b0, "R3 gap");
    end

    // R2 R4: exact limit
    run(J - 1, 1'b1, 1'b1, 1'b0, 1'b0, "R2 before limit");
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R2 R4 cut at limit");
    // R5: stays cut while active
    run(15, 1'b1, 1'b0, 1'b1, 1'b1, "R5 held cut");
    // R7: unjab interrupted one short
    run(U - 1, 1'b0, 1'b0, 1'b1, 1'b1, "R6 unjab counting");
    run(1, 1'b1, 1'b0, 1'b1, 1'b1, "R7 resume in unjab");
    run(U - 1, 1'b0, 1'b0, 1'b1, 1'b1, "R7 restarted unjab");
    run(1, 1'b0, 1'b1, 1'b0, 1'b1, "R6 R8 reopen, flag held");
    run(5, 1'b0, 1'b1, 1'b0, 1'b1, "R8 flag sticky");
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R8 clear pulse");
    run(2, 1'b0, 1'b1, 1'b0, 1'b0, "R8 stays clear");

    // R9: power-down during cut-off
    jab_event("R2 second event");
    run(3, 1'b1, 1'b0, 1'b1, 1'b1, "R5 cut");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R9 power-down release");
    // jabber count was cleared: J-1 more highs must not cut
    run(J - 1, 1'b1, 1'b1, 1'b0, 1'b1, "R9 count cleared");
    run(1, 1'b0, 1'b1, 1'b0, 1'b1, "R9 idle");

    // R9: deselect during cut-off, R8 clear and set on same edge
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R8 clear");
    run(J - 1, 1'b1, 1'b1, 1'b0, 1'b0, "R2 approach");
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R8 set wins over clear");
    run(2, 1'b1, 1'b0, 1'b1, 1'b1, "R5 cut");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R9 deselect release");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R9 back selected");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 20000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule